// File: doc/BRIEF.md
# Word Load Execution Unit

This block carries out the word-load group of a small 16-bit coprocessor that has eight general registers. An instruction word is offered on a valid/ready port. The block decodes it and, for a memory form, computes an effective address from a base register and either a 5-bit unsigned offset or an index register. The index addressing comes in three variants: plain, post-increment by two and pre-decrement by two. The block then issues one word read on a request/response memory port. When the data returns, it writes the data into the destination register and, where the mode calls for it, writes the adjusted index back.

Two immediate forms need no memory access and finish in the cycle they are accepted. The low-byte form loads an 8-bit constant into the low byte and clears the upper byte. The high-byte form replaces only the upper byte. Issued in that order, the two build any 16-bit constant. An index mode that does not exist, and any opcode outside this group, raise a one-cycle illegal strobe and leave every register unchanged. The register file can be read through a select port, so its contents are visible at the block's edge.

Top module: `ldw_unit`

## Requirements
- R1: After synchronous reset all eight registers read 0, `instr_ready` is 1, and `mem_req_valid`, `done` and `illegal` are 0.
- R2: A word with bits [15:11]=01001 loads the destination register (bits [10:8]) from address base register (bits [7:5]) plus the zero-extended offset in bits [4:0].
- R3: A word with bits [15:11]=01101 names the destination in [10:8], the base in [7:5] and the index in [4:2]. With bits [1:0]=00 it reads base plus index, and the index register is left unchanged.
- R4: With bits [1:0]=01 (post-increment) the read uses base plus the old index, and the index register then holds old index plus 2.
- R5: With bits [1:0]=10 (pre-decrement) the index register becomes old index minus 2, and the read uses base plus that new value.
- R6: In post-increment mode, when the index and destination fields name the same register, that register ends up holding the loaded data and no increment is applied.
- R7: A word with bits [15:11]=11110 writes bits [7:0] of the word into destination bits [7:0] and clears destination bits [15:8].
- R8: A word with bits [15:11]=11111 writes bits [7:0] of the word into destination bits [15:8] and keeps destination bits [7:0].
- R9: All address and index arithmetic wraps modulo 2^16, with no alignment check.
- R10: While a read request is pending, `mem_req_valid` stays 1 and `mem_req_addr` stays stable until `mem_req_ready` is seen. `instr_ready` is 0 from acceptance of a memory form until its response.
- R11: Register writes of a memory form occur only at the cycle where `mem_rsp_valid` is sampled in the response phase, and `done` is 1 in the following cycle. An immediate form raises `done` in the cycle after acceptance.
- R12: Bits [1:0]=11 of the indexed opcode, and any bits [15:11] outside the four values above, raise `illegal` for one cycle after acceptance, issue no memory request and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Block idle, word accepted this cycle if valid |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_addr | output | 16 | Read word address |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 16 | Read data |
| reg_sel | input | 3 | Register observation select |
| reg_val | output | 16 | Contents of the selected register |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | One-cycle illegal-instruction strobe |

## Verification
The response cycle of an indexed form writes the loaded data and the adjusted index to the register file in the same clock edge. When both target one register, the data write must win. Post-increment and pre-decrement loads are issued with distinct and with identical index and destination fields. After each response, the bench reads both registers through the select port and compares them with a register model kept in the bench. Requests are also held under back-pressure for varying cycle counts, and the bench confirms that the destination has not changed before the response arrives.

// File: rtl/ldw_pkg.sv
package ldw_pkg;

    localparam int INSTR_W = 16;
    localparam int SEL_W   = 3;
    localparam int IMM_W   = 8;
    localparam int OFFS_W  = 5;

    localparam logic [4:0] OPC_OFFS  = 5'b01001;
    localparam logic [4:0] OPC_INDEX = 5'b01101;
    localparam logic [4:0] OPC_IMMLO = 5'b11110;
    localparam logic [4:0] OPC_IMMHI = 5'b11111;

    typedef enum logic [2:0] {
        OP_OFFS,
        OP_IDX,
        OP_IDXINC,
        OP_IDXDEC,
        OP_IMMLO,
        OP_IMMHI,
        OP_BAD
    } ldw_op_e;

    typedef struct packed {
        ldw_op_e             op;
        logic [SEL_W-1:0]    rd;
        logic [SEL_W-1:0]    rb;
        logic [SEL_W-1:0]    ri;
        logic [OFFS_W-1:0]   offs;
        logic [IMM_W-1:0]    imm;
    } ldw_dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP
    } ldw_state_e;

    function automatic ldw_dec_t ldw_decode(input logic [INSTR_W-1:0] w);
        ldw_dec_t d;
        d.rd   = w[10:8];
        d.rb   = w[7:5];
        d.ri   = w[4:2];
        d.offs = w[4:0];
        d.imm  = w[7:0];
        case (w[15:11])
            OPC_OFFS:  d.op = OP_OFFS;
            OPC_INDEX: begin
                case (w[1:0])
                    2'b00:   d.op = OP_IDX;
                    2'b01:   d.op = OP_IDXINC;
                    2'b10:   d.op = OP_IDXDEC;
                    default: d.op = OP_BAD;
                endcase
            end
            OPC_IMMLO: d.op = OP_IMMLO;
            OPC_IMMHI: d.op = OP_IMMHI;
            default:   d.op = OP_BAD;
        endcase
        return d;
    endfunction

    function automatic logic is_mem_op(input ldw_op_e op);
        return (op == OP_OFFS) || (op == OP_IDX) ||
               (op == OP_IDXINC) || (op == OP_IDXDEC);
    endfunction

endpackage

// File: rtl/ldw_regfile.sv
module ldw_regfile #(
    parameter int DW    = 16,
    parameter int NREG  = 8,
    parameter int NRD   = 4,
    localparam int SW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pa_en,
    input  logic [SW-1:0]          pa_sel,
    input  logic [DW-1:0]          pa_data,
    input  logic                   pb_en,
    input  logic [SW-1:0]          pb_sel,
    input  logic [DW-1:0]          pb_data,
    input  logic [NRD-1:0][SW-1:0] rd_sel,
    output logic [NRD-1:0][DW-1:0] rd_data
);

    logic [NREG-1:0][DW-1:0] regs;

    // Port A (data) has priority over port B (index update) on a collision.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (pa_en && (pa_sel == SW'(g))) begin
                regs[g] <= pa_data;
            end else if (pb_en && (pb_sel == SW'(g))) begin
                regs[g] <= pb_data;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = regs[rd_sel[p]];
    end

endmodule

// File: rtl/ldw_agu.sv
module ldw_agu
    import ldw_pkg::*;
#(
    parameter int DW = 16
) (
    input  ldw_dec_t       dec,
    input  logic [DW-1:0]  base,
    input  logic [DW-1:0]  index,
    output logic [DW-1:0]  addr,
    output logic [DW-1:0]  new_index,
    output logic           index_wr
);

    localparam logic [DW-1:0] STEP = DW'(2);

    always_comb begin
        addr      = base + index;
        new_index = index;
        index_wr  = 1'b0;
        case (dec.op)
            OP_OFFS: begin
                addr = base + {{(DW-OFFS_W){1'b0}}, dec.offs};
            end
            OP_IDXINC: begin
                new_index = index + STEP;
                index_wr  = (dec.ri != dec.rd);
            end
            OP_IDXDEC: begin
                new_index = index - STEP;
                addr      = base + (index - STEP);
                index_wr  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ldw_ctrl.sv
module ldw_ctrl
    import ldw_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  ldw_dec_t           dec,
    input  logic [DW-1:0]      agu_addr,
    input  logic [DW-1:0]      agu_new_index,
    input  logic               agu_index_wr,
    input  logic [DW-1:0]      dest_cur,
    output logic               instr_ready,
    output logic               mem_req_valid,
    output logic [DW-1:0]      mem_req_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic [DW-1:0]      mem_rsp_data,
    output logic               pa_en,
    output logic [SEL_W-1:0]   pa_sel,
    output logic [DW-1:0]      pa_data,
    output logic               pb_en,
    output logic [SEL_W-1:0]   pb_sel,
    output logic [DW-1:0]      pb_data,
    output logic               wait_rsp,
    output logic               done,
    output logic               illegal
);

    ldw_state_e          state;
    logic [DW-1:0]       addr_q;
    logic [DW-1:0]       nidx_q;
    logic [SEL_W-1:0]    rd_q;
    logic [SEL_W-1:0]    ri_q;
    logic                idxwr_q;
    logic                accept;
    logic [DW-1:0]       hi_merge;

    assign instr_ready   = (state == ST_IDLE);
    assign accept        = instr_ready && instr_valid;
    assign mem_req_valid = (state == ST_REQ);
    assign mem_req_addr  = addr_q;
    assign wait_rsp      = (state == ST_RSP);

    always_comb begin
        hi_merge = dest_cur;
        hi_merge[DW-1 -: IMM_W] = dec.imm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            nidx_q  <= '0;
            rd_q    <= '0;
            ri_q    <= '0;
            idxwr_q <= 1'b0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_mem_op(dec.op)) begin
                            addr_q  <= agu_addr;
                            nidx_q  <= agu_new_index;
                            rd_q    <= dec.rd;
                            ri_q    <= dec.ri;
                            idxwr_q <= agu_index_wr;
                            state   <= ST_REQ;
                        end else if (dec.op == OP_IMMLO || dec.op == OP_IMMHI) begin
                            done <= 1'b1;
                        end else begin
                            illegal <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state <= ST_RSP;
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pa_en   = 1'b0;
        pa_sel  = rd_q;
        pa_data = mem_rsp_data;
        pb_en   = wait_rsp && mem_rsp_valid && idxwr_q;
        pb_sel  = ri_q;
        pb_data = nidx_q;
        if (wait_rsp && mem_rsp_valid) begin
            pa_en = 1'b1;
        end else if (accept && dec.op == OP_IMMLO) begin
            pa_en   = 1'b1;
            pa_sel  = dec.rd;
            pa_data = {{(DW-IMM_W){1'b0}}, dec.imm};
        end else if (accept && dec.op == OP_IMMHI) begin
            pa_en   = 1'b1;
            pa_sel  = dec.rd;
            pa_data = hi_merge;
        end
    end

endmodule

// File: rtl/ldw_unit.sv
module ldw_unit
    import ldw_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [INSTR_W-1:0]  instr_word,
    output logic                instr_ready,
    output logic                mem_req_valid,
    output logic [DW-1:0]       mem_req_addr,
    input  logic                mem_req_ready,
    input  logic                mem_rsp_valid,
    input  logic [DW-1:0]       mem_rsp_data,
    input  logic [SEL_W-1:0]    reg_sel,
    output logic [DW-1:0]       reg_val,
    output logic                done,
    output logic                illegal
);

    localparam int NRD = 4;

    ldw_dec_t                   dec;
    logic [NRD-1:0][SEL_W-1:0]  rsel;
    logic [NRD-1:0][DW-1:0]     rdat;
    logic [DW-1:0]              agu_addr;
    logic [DW-1:0]              agu_nidx;
    logic                       agu_iwr;
    logic                       pa_en, pb_en;
    logic [SEL_W-1:0]           pa_sel, pb_sel;
    logic [DW-1:0]              pa_data, pb_data;
    logic                       wait_rsp;

    assign dec     = ldw_decode(instr_word);
    assign rsel    = {reg_sel, dec.rd, dec.ri, dec.rb};
    assign reg_val = rdat[3];

    ldw_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .pa_en   (pa_en),
        .pa_sel  (pa_sel),
        .pa_data (pa_data),
        .pb_en   (pb_en),
        .pb_sel  (pb_sel),
        .pb_data (pb_data),
        .rd_sel  (rsel),
        .rd_data (rdat)
    );

    ldw_agu #(.DW(DW)) u_agu (
        .dec       (dec),
        .base      (rdat[0]),
        .index     (rdat[1]),
        .addr      (agu_addr),
        .new_index (agu_nidx),
        .index_wr  (agu_iwr)
    );

    ldw_ctrl #(.DW(DW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .dec           (dec),
        .agu_addr      (agu_addr),
        .agu_new_index (agu_nidx),
        .agu_index_wr  (agu_iwr),
        .dest_cur      (rdat[2]),
        .instr_ready   (instr_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .pa_en         (pa_en),
        .pa_sel        (pa_sel),
        .pa_data       (pa_data),
        .pb_en         (pb_en),
        .pb_sel        (pb_sel),
        .pb_data       (pb_data),
        .wait_rsp      (wait_rsp),
        .done          (done),
        .illegal       (illegal)
    );

endmodule

// File: rtl/ldw_unit_sva.sv
module ldw_unit_sva #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          instr_ready,
    input logic          mem_req_valid,
    input logic [DW-1:0] mem_req_addr,
    input logic          mem_req_ready,
    input logic          mem_rsp_valid,
    input logic          wait_rsp,
    input logic          done,
    input logic          illegal
);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (instr_ready && !mem_req_valid && !done && !illegal));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !instr_ready);

    assert_rsp_done_R11: assert property (@(posedge clk) disable iff (rst)
        (wait_rsp && mem_rsp_valid) |=> done);

    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!done && !mem_req_valid));

endmodule

bind ldw_unit ldw_unit_sva #(.DW(DW)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .instr_ready   (instr_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .wait_rsp      (wait_rsp),
    .done          (done),
    .illegal       (illegal)
);

// File: tb/ldw_unit_test.sv
`timescale 1ns/1ps
module ldw_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        instr_ready;
    logic        mem_req_valid;
    logic [15:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_val;
    logic        done;
    logic        illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] mdl [8];

    always #2.5 clk = ~clk;

    ldw_unit uut (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_ready(instr_ready), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .reg_sel(reg_sel), .reg_val(reg_val), .done(done), .illegal(illegal)
    );

    // {instr, expected address, expected destination, expected index}
    localparam int NV = 15;
    localparam logic [63:0] VEC [NV] = '{
        64'hF134_0000_0034_0034,
        64'hF912_0000_1234_1234,
        64'hF210_0000_0010_0010,
        64'hF3FE_0000_00FE_00FE,
        64'hFBFF_0000_FFFE_FFFE,
        64'h4C25_1239_EDC6_EDC6,
        64'h6D29_1244_EDBB_0012,
        64'h6E2A_1244_EDBB_0010,
        64'h6F2C_1232_EDCD_FFFE,
        64'h6A29_1244_EDBB_EDBB,
        64'hF0FF_0000_00FF_00FF,
        64'hF8AB_0000_ABFF_ABFF,
        64'hF001_0000_0001_0001,
        64'h4C7F_001D_FFE2_FFE2,
        64'h6D22_1233_EDCC_FFFF
    };
    localparam logic [NV-1:0] WRAP = 15'b110_0001_0000_0000;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [2:0] s, output logic [15:0] v);
        reg_sel = s;
        #0.5;
        v = reg_val;
    endtask

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:11] == 5'b01001) return "R2";
        if (w[15:11] == 5'b11110) return "R7";
        if (w[15:11] == 5'b11111) return "R8";
        if (w[1:0] == 2'b00) return "R3";
        if (w[1:0] == 2'b10) return "R5";
        if (w[10:8] == w[4:2]) return "R6";
        return "R4";
    endfunction

    task automatic run_vec(input int i);
        logic [15:0] w, ea, erd, eri, v;
        logic mem, idx;
        string t;
        w = VEC[i][63:48]; ea = VEC[i][47:32]; erd = VEC[i][31:16]; eri = VEC[i][15:0];
        mem = (w[15:11] == 5'b01001) || (w[15:11] == 5'b01101);
        idx = (w[15:11] == 5'b01101);
        t = tag_of(w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
        if (mem) begin
            chk({t, " addr"}, mem_req_addr, ea);
            if (WRAP[i]) chk("R9 wrapped addr", mem_req_addr, ea);
            chk("R10 busy", {15'b0, instr_ready}, 16'd0);
            for (int h = 0; h < i % 3; h++) begin
                @(negedge clk);
                chk("R10 req held", {mem_req_valid, mem_req_addr[14:0]}, {1'b1, ea[14:0]});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            peek(w[10:8], v);
            chk("R11 no early write", v, mdl[w[10:8]]);
            chk("R11 no early done", {15'b0, done}, 16'd0);
            mem_rsp_valid = 1'b1; mem_rsp_data = ~ea;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        chk("R11 done", {15'b0, done}, 16'd1);
        mdl[w[10:8]] = erd;
        if (idx) mdl[w[4:2]] = eri;
        peek(w[10:8], v);
        chk({t, " dest"}, v, erd);
        if (idx) begin
            peek(w[4:2], v);
            chk({t, " index"}, v, eri);
        end
    endtask

    task automatic run_bad(input logic [15:0] w);
        logic [15:0] v;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
        chk("R12 strobe", {14'b0, illegal, done}, 16'd2);
        chk("R12 no request", {15'b0, mem_req_valid}, 16'd0);
        for (int r = 0; r < 8; r++) begin
            peek(3'(r), v);
            chk("R12 regs kept", v, mdl[r]);
        end
    endtask

    task automatic check_reset();
        logic [15:0] v;
        chk("R1 idle", {12'b0, instr_ready, mem_req_valid, done, illegal}, 16'h0008);
        for (int r = 0; r < 8; r++) begin
            peek(3'(r), v);
            chk("R1 reg zero", v, 16'h0000);
            mdl[r] = '0;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset();
        for (int i = 0; i < NV; i++) run_vec(i);
        run_bad(16'h6D2B);
        run_bad(16'h0000);
        run_bad(16'h7123);
        // mid-run reset clears a populated register file
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule